// File: doc/BRIEF.md
# Shadow-Buffered PWM Generator

This block drives one pulse-width-modulated line from a free-running period counter of `WIDTH` bits and a magnitude comparator. A period lasts exactly 2^WIDTH clocks. The line is high for the first D counts of a period, where D is the active duty code, and low for the rest.

Duty codes arrive on a small valid/ready stream and may come in any cycle. Each accepted code goes into a pending register. It moves into the active register only at the boundary where the counter rolls over to zero. A change in the middle of a period therefore never cuts a pulse short or adds a stray one. A strobe marks the first clock of every period, which is the cycle where a newly loaded duty is first in force.

A second output carries the same waveform for loads that switch on a low level; the `POLARITY` parameter selects whether it is inverted. The `FULL_ON_AT_MAX` parameter sets what the all-ones code means: either 2^WIDTH−1 high counts out of 2^WIDTH, or a line held high for the whole period. Write handshake rules: `duty_ready` is always high, so a code is taken on every clock edge where `duty_valid` is high. Back-pressure never occurs, and a producer may hold `duty_valid` high for several cycles. Each of those cycles counts as a fresh write.

Top module: `pwm_shadow_gen`

## Requirements
- R1: The period counter steps by one each clock and wraps from 2^WIDTH−1 to 0, so `period_start` pulses exactly once every 2^WIDTH clocks.
- R2: `pwm_out` is high in the cycles where the count is strictly below the active duty D and low otherwise, which gives exactly D high cycles per period.
- R3: With active duty 0, `pwm_out` stays low for the whole period.
- R4: With `FULL_ON_AT_MAX` = 0 and active duty all ones, `pwm_out` is high for 2^WIDTH−1 cycles and low in the cycle where the count is 2^WIDTH−1.
- R5: With `FULL_ON_AT_MAX` = 1 and active duty all ones, `pwm_out` is high in every cycle of the period.
- R6: `period_start` is high for exactly one clock, in the cycle where the count is 0. That is the first cycle in which a newly loaded duty shapes `pwm_out`.
- R7: `pwm_load_out` equals `pwm_out` when `POLARITY` is POL_HIGH (encoding 0) and is its complement when `POLARITY` is POL_LOW (encoding 1).
- R8: While `rst` is high, and in the first cycle after it falls, the count is 0, the active and pending duty are 0, `pwm_out` and `period_start` are low, and `pwm_load_out` is at its inactive level (high for POL_LOW). The first `period_start` after release comes 2^WIDTH clocks after the release edge.
- R9: A duty code accepted in any cycle of a period, including the last cycle (count 2^WIDTH−1), does not change the current period and takes effect from the next period start.
- R10: When several codes are accepted within one period, only the last of them becomes the next active duty.
- R11: `duty_ready` is high in every cycle, so every cycle with `duty_valid` high is an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| duty_valid | input | 1 | Duty code offered this cycle |
| duty_ready | output | 1 | Always high; a write is never stalled |
| duty_data | input | WIDTH | Requested duty code (high counts per period) |
| pwm_out | output | 1 | PWM waveform, active high |
| pwm_load_out | output | 1 | PWM waveform at the load polarity chosen by `POLARITY` |
| period_start | output | 1 | One-clock strobe in the first cycle of each period |

## Verification
The bench aims at the duty extremes: code 0, code 1, and the all-ones code in both full-scale modes. A comparator with `<=` in place of `<` would show one extra high count at zero or one at the top. A design without the full-scale override would drop the line in the last count of the period. Writes are placed in the final cycle before rollover, and bursts of writes are placed inside one period. A shadow that loads a cycle late would lose the boundary write, one that loads mid-period would bend the waveform already in progress, and one that keeps the first write of a burst would apply a stale code. A reset in the middle of a period checks that the old duty is discarded and that the first strobe comes a full period later.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  // Level at which the attached load is switched on.
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pol_e;

  // Idle (off) level of the load-facing output for a given polarity.
  function automatic logic idle_level(input pol_e p);
    return (p == POL_LOW);
  endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cnt_nxt,
  output logic             wrap_nxt,
  output logic             start_q
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_comb begin
    cnt_nxt  = cnt_q + STEP;
    wrap_nxt = (cnt_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      start_q <= wrap_nxt;
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == WIDTH'($past(cnt_q) + STEP)));

  generate
    if (WIDTH > 1) begin : g_pulse_chk
      // R6
      start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);
    end
  endgenerate

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             load_en,
  output logic [WIDTH-1:0] active_q,
  output logic [WIDTH-1:0] active_nxt
);

  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] pend_nxt;

  // A write in the load cycle bypasses the pending register.
  always_comb begin
    pend_nxt   = wr_valid ? wr_data : pend_q;
    active_nxt = load_en ? pend_nxt : active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      active_q <= '0;
    end else begin
      pend_q   <= pend_nxt;
      active_q <= active_nxt;
    end
  end

endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out
  import pwm_gen_pkg::*;
#(
  parameter int   WIDTH          = 8,
  parameter bit   FULL_ON_AT_MAX = 1'b0,
  parameter pol_e POLARITY       = POL_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic [WIDTH-1:0] duty_nxt,
  output logic             pwm_q,
  output logic             load_q
);

  localparam logic [WIDTH-1:0] DUTY_TOP = '1;
  localparam logic             INV      = idle_level(POLARITY);

  logic below;
  logic pwm_nxt;

  assign below = (cnt_nxt < duty_nxt);

  generate
    if (FULL_ON_AT_MAX) begin : g_full
      assign pwm_nxt = below || (duty_nxt == DUTY_TOP);
    end else begin : g_strict
      assign pwm_nxt = below;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q  <= 1'b0;
      load_q <= INV;
    end else begin
      pwm_q  <= pwm_nxt;
      load_q <= pwm_nxt ^ INV;
    end
  end

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_gen_pkg::*;
#(
  parameter int   WIDTH          = 8,
  parameter bit   FULL_ON_AT_MAX = 1'b0,
  parameter pol_e POLARITY       = POL_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             duty_valid,
  output logic             duty_ready,
  input  logic [WIDTH-1:0] duty_data,
  output logic             pwm_out,
  output logic             pwm_load_out,
  output logic             period_start
);

  localparam logic [WIDTH-1:0] DUTY_TOP = '1;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic             wrap_nxt;
  logic             start_q;
  logic [WIDTH-1:0] active_q;
  logic [WIDTH-1:0] active_nxt;
  logic             pwm_q;
  logic             load_q;

  assign duty_ready = 1'b1;

  pwm_period_ctr #(.WIDTH(WIDTH)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .wrap_nxt (wrap_nxt),
    .start_q  (start_q)
  );

  pwm_duty_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (duty_valid),
    .wr_data    (duty_data),
    .load_en    (wrap_nxt),
    .active_q   (active_q),
    .active_nxt (active_nxt)
  );

  pwm_cmp_out #(
    .WIDTH          (WIDTH),
    .FULL_ON_AT_MAX (FULL_ON_AT_MAX),
    .POLARITY       (POLARITY)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .cnt_nxt  (cnt_nxt),
    .duty_nxt (active_nxt),
    .pwm_q    (pwm_q),
    .load_q   (load_q)
  );

  assign pwm_out      = pwm_q;
  assign pwm_load_out = load_q;
  assign period_start = start_q;

  // R9
  duty_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_q) |-> start_q);

  // R10
  last_write_chk: assert property (@(posedge clk) disable iff (rst)
    (start_q && $past(duty_valid)) |-> (active_q == $past(duty_data)));

  // R3
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q == '0) |-> !pwm_q);

  // R6
  start_count_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (cnt_q == '0));

  generate
    if (FULL_ON_AT_MAX) begin : g_full_chk
      // R5
      full_on_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q == DUTY_TOP) |-> pwm_q);
    end else begin : g_strict_chk
      // R4
      top_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == DUTY_TOP) |-> !pwm_q);
    end
  endgenerate

endmodule

// File: tb/test_pwm_shadow_gen.sv
module test_pwm_shadow_gen;
  import pwm_gen_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic       duty_valid;
  logic [7:0] duty_data;
  logic       rdy_a, pwm_a, load_a, start_a;
  logic       rdy_b, pwm_b, load_b, start_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  bit live     = 1'b0;

  always #4 clk = ~clk;

  // Instance A: 8 bits, strict compare, active-high load.
  pwm_shadow_gen #(.WIDTH(8), .FULL_ON_AT_MAX(1'b0), .POLARITY(POL_HIGH)) i_pwm_shadow_gen (
    .clk(clk), .rst(rst), .duty_valid(duty_valid), .duty_ready(rdy_a),
    .duty_data(duty_data), .pwm_out(pwm_a), .pwm_load_out(load_a),
    .period_start(start_a));

  // Instance B: 4 bits, full-on at top code, active-low load.
  pwm_shadow_gen #(.WIDTH(4), .FULL_ON_AT_MAX(1'b1), .POLARITY(POL_LOW)) i_pwm_shadow_gen_alt (
    .clk(clk), .rst(rst), .duty_valid(duty_valid), .duty_ready(rdy_b),
    .duty_data(duty_data[3:0]), .pwm_out(pwm_b), .pwm_load_out(load_b),
    .period_start(start_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference state per instance, derived from the requirements.
  logic [7:0] m_cnt [2];
  logic [7:0] m_act [2];
  logic [7:0] m_pnd [2];
  logic       m_st  [2];

  function automatic logic [7:0] top_of(input int i);
    return (i == 0) ? 8'hFF : 8'h0F;
  endfunction

  function automatic logic exp_pwm(input int i);
    if (i == 1 && m_act[i] == top_of(i)) return 1'b1;
    return m_cnt[i] < m_act[i];
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      logic [7:0] nc;
      logic [7:0] np;
      logic [7:0] d;
      d  = duty_data & top_of(i);
      nc = (m_cnt[i] + 8'd1) & top_of(i);
      np = duty_valid ? d : m_pnd[i];
      if (rst) begin
        m_cnt[i] <= 8'd0; m_act[i] <= 8'd0; m_pnd[i] <= 8'd0; m_st[i] <= 1'b0;
      end else begin
        m_cnt[i] <= nc;
        m_pnd[i] <= np;
        m_st[i]  <= (nc == 8'd0);
        if (nc == 8'd0) m_act[i] <= np;
      end
    end
  end

  function automatic string pwm_tag(input int i);
    if (m_act[i] == 8'd0) return "R3";
    if (m_act[i] == top_of(i)) return (i == 0) ? "R4" : "R5";
    return "R2";
  endfunction

  // Cycle-by-cycle comparison, sampled on the falling edge.
  always @(negedge clk) begin
    if (live) begin
      check(pwm_a == exp_pwm(0), pwm_tag(0), pwm_a, exp_pwm(0));
      check(pwm_b == exp_pwm(1), pwm_tag(1), pwm_b, exp_pwm(1));
      check(load_a == exp_pwm(0), "R7", load_a, exp_pwm(0));
      check(load_b == !exp_pwm(1), "R7", load_b, !exp_pwm(1));
      check(start_a == m_st[0], "R1 R6", start_a, m_st[0]);
      check(start_b == m_st[1], "R1 R6", start_b, m_st[1]);
      check(rdy_a && rdy_b, "R11", rdy_a && rdy_b, 1);
    end
  end

  task automatic set_duty(input logic [7:0] d);
    duty_valid = 1'b1;
    duty_data  = d;
    @(negedge clk);
    duty_valid = 1'b0;
  endtask

  task automatic wait_start(input int which);
    do @(negedge clk); while (!((which == 0) ? start_a : start_b));
  endtask

  // Counts high samples over n cycles, beginning at the current falling edge.
  task automatic count_high(input int which, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      if (k != 0) @(negedge clk);
      case (which)
        0: hi += int'(pwm_a);
        1: hi += int'(pwm_b);
        default: hi += int'(load_b);
      endcase
    end
  endtask

  task automatic measure(input int which, input int n, input int exp, input string tag);
    int hi;
    wait_start((which == 0) ? 0 : 1);
    count_high(which, n, hi);
    check(hi == exp, tag, hi, exp);
  endtask

  task automatic check_reset_state();
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R8", {pwm_a, pwm_b}, 0);
    check(load_a == 1'b0 && load_b == 1'b1, "R8", {load_a, load_b}, 1);
    check(start_a == 1'b0 && start_b == 1'b0, "R8", {start_a, start_b}, 0);
  endtask

  task automatic first_start_after_release();
    int n;
    n = 0;
    rst = 1'b0;
    do begin @(negedge clk); n++; end while (!start_a);
    check(n == 256, "R8 R1", n, 256);
  endtask

  initial begin
    void'($urandom(32'd7));
    rst = 1'b1; duty_valid = 1'b0; duty_data = 8'd0;
    repeat (3) @(negedge clk);
    check_reset_state();
    live = 1'b1;
    first_start_after_release();

    // Directed duty extremes.
    set_duty(8'd0);   measure(0, 256, 0,   "R3");
    set_duty(8'd1);   measure(0, 256, 1,   "R2");
    set_duty(8'd128); measure(0, 256, 128, "R2");
    set_duty(8'd254); measure(0, 256, 254, "R2");
    set_duty(8'd255); measure(0, 256, 255, "R4");
    measure(1, 16, 16, "R5");
    measure(2, 16, 0,  "R7");
    set_duty(8'h05);  measure(1, 16, 5, "R2");
    measure(2, 16, 11, "R7");

    // R10: burst of writes within one period, last one wins.
    wait_start(0);
    repeat (10) @(negedge clk);
    set_duty(8'd40);
    repeat (30) @(negedge clk);
    set_duty(8'd90);
    measure(0, 256, 90, "R10");

    // R9: write in the final count applies to the period that starts next.
    begin
      int hi;
      wait_start(0);
      repeat (255) @(negedge clk);
      duty_valid = 1'b1; duty_data = 8'd200;
      @(negedge clk);
      duty_valid = 1'b0;
      check(start_a == 1'b1, "R6", start_a, 1);
      count_high(0, 256, hi);
      check(hi == 200, "R9", hi, 200);
      // R9: mid-period write leaves the running period untouched.
      wait_start(0);
      repeat (50) @(negedge clk);
      set_duty(8'd10);
      count_high(0, 205, hi);
      check(hi == 149, "R9", hi, 149);
      measure(0, 256, 10, "R9");
    end

    // Random duties, each measured over a full period.
    for (int r = 0; r < 20; r++) begin
      logic [7:0] d;
      d = 8'($urandom);
      set_duty(d);
      measure(0, 256, int'(d), "R2");
    end

    // Random background writes, compared cycle by cycle.
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      duty_valid = ($urandom % 40) == 0;
      duty_data  = 8'($urandom);
    end
    duty_valid = 1'b0;

    // Reset in the middle of a period.
    set_duty(8'd100);
    wait_start(0);
    repeat (60) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    first_start_after_release();
    begin
      int hi;
      count_high(0, 256, hi);
      check(hi == 0, "R8", hi, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule